// File: doc/BRIEF.md
# Pipelined ADC Scan Sequencer

This block is an SPI master that walks a set of input channels on a multichannel successive-approximation ADC. The converter answers each request two frames late, so the block has to realign what it receives. A trigger starts one scan. For every channel enabled in the mask, in rising index order, the block sends one 16-bit command frame. It then sends two padding frames so that the last results can come back.

Each received word is matched to the channel that was requested two frames earlier. The block compares the channel tag the converter echoes in the top nibble against that channel, and writes the sample field into that channel's slot of an output buffer. A one-cycle done pulse closes the scan. The SPI clock comes from the system clock through a fixed divider. Chip select goes high after every frame and stays high for a guaranteed minimum time.

Top module: `adc_scan_seq`

## Requirements
- R1: Each command word has bit 12 set (manual channel select), bit 11 set (write settings), the channel number in bits 10:7 and the range-doubling input in bit 6. The range input is latched at the trigger. All other bits are zero.
- R2: The block sends exactly one command frame per enabled channel of the mask latched at the trigger, lowest index first.
- R3: A scan of K enabled channels takes K+2 frames. The last two frames repeat the final command word bit for bit. With one channel enabled this gives three frames: command, repeat, read.
- R4: The SPI link runs in mode 0, MSB first, with 16 SCLK periods per frame. SCLK idles low whenever chip select is high, and MOSI changes only while SCLK is low.
- R5: Between frames of a scan, chip select stays high for at least CS_GAP+1 system clocks. It is high after the final frame.
- R6: The word received in frame N+2 belongs to the channel requested in frame N. The words of the first two frames are discarded. The stored sample is received bits 11 down to 12-RES_BITS.
- R7: A received tag (bits 15:12) that differs from the expected channel sets tagErr. The sample is still stored. tagErr clears on the next accepted trigger.
- R8: done is a one-cycle pulse. For K>0 it is high right after the clock edge that lies (K+2)*(1+32*SCLK_DIV+CS_GAP) cycles after the edge that accepted the trigger.
- R9: A trigger while a scan is busy does not disturb the scan. It adds one to overrunCnt, which saturates at all ones.
- R10: A trigger with an empty mask sends no frame and pulses done right after the accepting edge.
- R11: After reset, csN=1, sclk=0, done=0, tagErr=0, overrunCnt=0 and every buffer slot is zero.
- R12: Buffer slots of channels not enabled in a scan keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Starts a scan when idle |
| chMask | input | NUM_CH | Channel enable mask, bit i = channel i |
| rangeDbl | input | 1 | Requests the doubled input range |
| sclk | output | 1 | SPI clock, mode 0 |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Command data to the converter |
| miso | input | 1 | Result data from the converter |
| sampleBuf | output | NUM_CH*RES_BITS | Sample buffer, channel c at [c*RES_BITS +: RES_BITS] |
| tagErr | output | 1 | Echoed tag mismatch in the last scan |
| done | output | 1 | One-cycle end-of-scan pulse |
| overrunCnt | output | OVR_W | Saturating count of triggers ignored while busy |

## Verification
Each frame costs exactly 1+32*SCLK_DIV+CS_GAP cycles, so done is due a fixed number of edges after the accepting edge. The bench counts that many edges from the trigger. It checks that done is still low one edge early and high at the due edge, which pins the R8 timing exactly. The buffer, the tag error and the captured command frames are all final before done rises, so the bench reads them after the pulse. The empty-mask case is checked on the negative edge right after the accepting edge.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int FRAME_BITS = 16;
  localparam int CH_FIELD_W = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_XFER, ST_GAP} seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic                  start;
    logic                  loadCmd;
    logic                  cmdValid;
    logic [CH_FIELD_W-1:0] cmdCh;
    logic                  shiftBit;
    logic                  sampleBit;
    logic                  frameEnd;
    logic                  scanDone;
  } seqStrobes_t;
endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int SCLK_DIV = 2,
  parameter int CS_GAP   = 2,
  parameter int OVR_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trig,
  input  logic [NUM_CH-1:0] chMask,
  output seqStrobes_t       stb,
  output logic              sclk,
  output logic              csN,
  output logic [OVR_W-1:0]  overrunCnt
);
  localparam int DIV_W = $clog2(SCLK_DIV + 1);
  localparam int GAP_W = $clog2(CS_GAP + 1);
  localparam int FL_W  = $clog2(NUM_CH + 3);

  seqState_t         state;
  logic [NUM_CH-1:0] pendMask;
  logic [FL_W-1:0]   framesLeft;
  logic [DIV_W-1:0]  divCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic [3:0]        bitCnt;
  logic [CH_FIELD_W-1:0] nextCh;
  logic              hasNext;
  logic              divWrap;
  logic              gapWrap;

  function automatic int popCount(logic [NUM_CH-1:0] m);
    int n = 0;
    for (int i = 0; i < NUM_CH; i++) n += int'(m[i]);
    return n;
  endfunction

  // lowest pending channel
  always_comb begin
    nextCh = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pendMask[i]) nextCh = CH_FIELD_W'(i);
    end
  end
  assign hasNext = |pendMask;
  assign divWrap = (divCnt == DIV_W'(SCLK_DIV - 1));
  assign gapWrap = (gapCnt == GAP_W'(CS_GAP - 1));

  always_comb begin
    stb = '0;
    stb.cmdCh = nextCh;
    unique case (state)
      ST_IDLE: if (trig) begin
        if (|chMask) stb.start = 1'b1;
        else         stb.scanDone = 1'b1;
      end
      ST_LOAD: begin
        stb.loadCmd  = 1'b1;
        stb.cmdValid = hasNext;
      end
      ST_XFER: if (divWrap) begin
        if (!sclk)               stb.sampleBit = 1'b1;
        else if (bitCnt == 4'hF) stb.frameEnd  = 1'b1;
        else                     stb.shiftBit  = 1'b1;
      end
      ST_GAP: if (gapWrap && framesLeft == '0) stb.scanDone = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      pendMask   <= '0;
      framesLeft <= '0;
      divCnt     <= '0;
      gapCnt     <= '0;
      bitCnt     <= '0;
      sclk       <= 1'b0;
      csN        <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (trig && |chMask) begin
          pendMask   <= chMask;
          framesLeft <= FL_W'(popCount(chMask) + 2);
          state      <= ST_LOAD;
        end
        ST_LOAD: begin
          if (hasNext) pendMask[nextCh] <= 1'b0;
          csN    <= 1'b0;
          sclk   <= 1'b0;
          divCnt <= '0;
          bitCnt <= '0;
          state  <= ST_XFER;
        end
        ST_XFER: begin
          if (divWrap) begin
            divCnt <= '0;
            sclk   <= ~sclk;
            if (sclk) begin
              if (bitCnt == 4'hF) begin
                csN        <= 1'b1;
                gapCnt     <= '0;
                framesLeft <= framesLeft - 1'b1;
                state      <= ST_GAP;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (gapWrap) state <= (framesLeft == '0) ? ST_IDLE : ST_LOAD;
          else         gapCnt <= gapCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) overrunCnt <= '0;
    else if (trig && state != ST_IDLE && overrunCnt != '1)
      overrunCnt <= overrunCnt + 1'b1;
  end

  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);
  assert_cs_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> csN);
  assert_cs_min_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |=> csN);
  assert_overrun_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    (trig && state != ST_IDLE && overrunCnt != '1) |=> (overrunCnt == $past(overrunCnt) + 1'b1));
  assert_overrun_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!trig || state == ST_IDLE) |=> $stable(overrunCnt));
endmodule

// File: rtl/adc_scan_dp.sv
module adc_scan_dp
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int RES_BITS = 12
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  seqStrobes_t                  stb,
  input  logic                         rangeDbl,
  input  logic                         miso,
  input  logic                         sclk,
  output logic                         mosi,
  output logic [NUM_CH*RES_BITS-1:0]   sampleBuf,
  output logic                         tagErr,
  output logic                         done
);
  localparam int LAT = 3;  // pipe depth: current frame plus two of latency

  logic                            rangeLat;
  logic [FRAME_BITS-1:0]           txShift;
  logic [FRAME_BITS-1:0]           lastCmd;
  logic [FRAME_BITS-1:0]           rxShift;
  logic [LAT-1:0]                  pVal;
  logic [LAT-1:0][CH_FIELD_W-1:0]  pCh;
  logic                            capture;

  function automatic logic [FRAME_BITS-1:0] mkCmd(logic [CH_FIELD_W-1:0] ch, logic rng);
    logic [FRAME_BITS-1:0] w;
    w       = '0;
    w[12]   = 1'b1;
    w[11]   = 1'b1;
    w[10:7] = ch;
    w[6]    = rng;
    return w;
  endfunction

  assign mosi    = txShift[FRAME_BITS-1];
  assign capture = stb.frameEnd && pVal[LAT-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rangeLat <= 1'b0;
      txShift  <= '0;
      lastCmd  <= '0;
      rxShift  <= '0;
      pVal     <= '0;
      pCh      <= '0;
      tagErr   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= stb.scanDone;
      if (stb.start) begin
        rangeLat <= rangeDbl;
        tagErr   <= 1'b0;
        pVal     <= '0;
      end
      if (stb.loadCmd) begin
        if (stb.cmdValid) begin
          txShift <= mkCmd(stb.cmdCh, rangeLat);
          lastCmd <= mkCmd(stb.cmdCh, rangeLat);
        end else begin
          txShift <= lastCmd;
        end
        pVal <= {pVal[LAT-2:0], stb.cmdValid};
        pCh  <= {pCh[LAT-2:0], stb.cmdCh};
      end
      if (stb.shiftBit)  txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
      if (stb.sampleBit) rxShift <= {rxShift[FRAME_BITS-2:0], miso};
      if (capture && rxShift[15:12] != pCh[LAT-1]) tagErr <= 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
    logic [RES_BITS-1:0] slot;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) slot <= '0;
      else if (capture && pCh[LAT-1] == CH_FIELD_W'(c))
        slot <= rxShift[11 -: RES_BITS];
    end
    assign sampleBuf[c*RES_BITS +: RES_BITS] = slot;
  end

  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));
  assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.start |=> !tagErr);
  assert_discard_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.frameEnd && !pVal[LAT-1]) |=> $stable(sampleBuf));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int RES_BITS = 12,
  parameter int SCLK_DIV = 2,
  parameter int CS_GAP   = 2,
  parameter int OVR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       trig,
  input  logic [NUM_CH-1:0]          chMask,
  input  logic                       rangeDbl,
  output logic                       sclk,
  output logic                       csN,
  output logic                       mosi,
  input  logic                       miso,
  output logic [NUM_CH*RES_BITS-1:0] sampleBuf,
  output logic                       tagErr,
  output logic                       done,
  output logic [OVR_W-1:0]           overrunCnt
);
  seqStrobes_t stb;

  adc_scan_ctrl #(
    .NUM_CH(NUM_CH), .SCLK_DIV(SCLK_DIV), .CS_GAP(CS_GAP), .OVR_W(OVR_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .trig(trig), .chMask(chMask), .stb(stb),
    .sclk(sclk), .csN(csN), .overrunCnt(overrunCnt)
  );

  adc_scan_dp #(
    .NUM_CH(NUM_CH), .RES_BITS(RES_BITS)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rangeDbl(rangeDbl), .miso(miso),
    .sclk(sclk), .mosi(mosi), .sampleBuf(sampleBuf), .tagErr(tagErr), .done(done)
  );
endmodule

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  localparam int NUM_CH   = 16;
  localparam int RES_BITS = 12;
  localparam int SCLK_DIV = 2;
  localparam int CS_GAP   = 2;
  localparam int OVR_W    = 8;
  localparam int FRAME_T  = 1 + 32*SCLK_DIV + CS_GAP;

  typedef struct packed {
    logic [15:0] mask;
    logic        rng;
    logic [7:0]  seed;
    logic [4:0]  bad;   // channel whose echoed tag is corrupted, 31 = none
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{16'hFFFF, 1'b1, 8'd3,  5'd31},
    '{16'h0020, 1'b0, 8'd7,  5'd31},
    '{16'h8001, 1'b1, 8'd11, 5'd15},
    '{16'h0A50, 1'b0, 8'd2,  5'd31},
    '{16'h1234, 1'b1, 8'd9,  5'd4}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trig = 1'b0;
  logic [NUM_CH-1:0] chMask = '0;
  logic rangeDbl = 1'b0;
  logic sclk, csN, mosi, tagErr, done;
  logic misoR = 1'b0;
  logic [NUM_CH*RES_BITS-1:0] sampleBuf;
  logic [OVR_W-1:0] overrunCnt;

  always #2.5 clk = ~clk;

  adc_scan_seq #(
    .NUM_CH(NUM_CH), .RES_BITS(RES_BITS), .SCLK_DIV(SCLK_DIV), .CS_GAP(CS_GAP), .OVR_W(OVR_W)
  ) i_adc_scan_seq (
    .clk(clk), .rstN(rstN), .trig(trig), .chMask(chMask), .rangeDbl(rangeDbl),
    .sclk(sclk), .csN(csN), .mosi(mosi), .miso(misoR), .sampleBuf(sampleBuf),
    .tagErr(tagErr), .done(done), .overrunCnt(overrunCnt)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // converter model
  logic [15:0] cmdLog [32];
  int          bitLog [32];
  int          frameNo = 0;
  int          bitsInFrame = 0;
  logic [15:0] rxAcc = '0;
  logic [15:0] txW = '0;
  int          seed = 0;
  int          badCh = 31;

  function automatic int sampleVal(int ch, int sd);
    return (ch*97 + sd*13 + 5) % (1 << RES_BITS);
  endfunction

  function automatic logic [15:0] expCmd(int ch, logic rng);
    return 16'h1800 | 16'(ch << 7) | (rng ? 16'h0040 : 16'h0000);
  endfunction

  function automatic logic [15:0] respond(int n);
    int ch;
    int tag;
    if (n < 2) return 16'hA5A5;
    ch  = int'(cmdLog[n-2][10:7]);
    tag = (ch == badCh) ? (ch ^ 1) : ch;
    return 16'((tag << 12) | (sampleVal(ch, seed) << (12 - RES_BITS)));
  endfunction

  always @(negedge csN) begin
    txW = respond(frameNo);
    misoR = txW[15];
    rxAcc = '0;
    bitsInFrame = 0;
  end
  always @(negedge sclk) if (!csN) begin
    txW = {txW[14:0], 1'b0};
    misoR = txW[15];
  end
  always @(posedge sclk) begin
    rxAcc = {rxAcc[14:0], mosi};
    bitsInFrame++;
  end
  always @(posedge csN) if (rstN && frameNo < 32) begin
    cmdLog[frameNo] = rxAcc;
    bitLog[frameNo] = bitsInFrame;
    frameNo++;
  end

  // link monitor, sampled away from the active edge
  int highRun = 0;
  int gapViol = 0;
  int idleViol = 0;
  always @(negedge clk) if (rstN) begin
    if (csN && sclk) idleViol++;
    if (csN) highRun++;
    else begin
      if (highRun != 0 && highRun < CS_GAP + 1) gapViol++;
      highRun = 0;
    end
  end

  logic [RES_BITS-1:0] expBuf [NUM_CH];

  task automatic run_scan(input logic [15:0] mask, input logic rng, input int sd,
                          input int bad, input int extra);
    int k = 0;
    int chs [16];
    int total;
    bit expErr = 0;
    for (int c = 0; c < NUM_CH; c++) if (mask[c]) begin chs[k] = c; k++; end
    seed = sd;
    badCh = bad;
    frameNo = 0;
    total = (k + 2) * FRAME_T;
    @(negedge clk);
    trig = 1'b1; chMask = mask; rangeDbl = rng;
    @(posedge clk);
    if (k == 0) begin
      @(negedge clk);
      trig = 1'b0;
      check(done === 1'b1, "R10", "empty-mask done", int'(done), 1);
      @(negedge clk);
      check(done === 1'b0, "R10", "empty-mask done width", int'(done), 0);
      check(frameNo == 0, "R10", "empty-mask frames", frameNo, 0);
    end else begin
      for (int c = 1; c < total; c++) begin
        @(negedge clk);
        trig = (extra == 1 && (c == 10 || c == 30)) || (extra == 2 && c <= 300);
        chMask = ~mask; rangeDbl = ~rng;
        @(posedge clk);
      end
      @(negedge clk);
      trig = 1'b0;
      check(done === 1'b0, "R8", "done early", int'(done), 0);
      @(posedge clk);
      @(negedge clk);
      check(done === 1'b1, "R8", "done at due edge", int'(done), 1);
      check(frameNo == k + 2, "R3", "frame count", frameNo, k + 2);
      for (int i = 0; i < k; i++)
        check(cmdLog[i] == expCmd(chs[i], rng), "R1 R2", "command word", int'(cmdLog[i]), int'(expCmd(chs[i], rng)));
      for (int i = k; i < k + 2; i++)
        check(cmdLog[i] == expCmd(chs[k-1], rng), "R3", "padding word", int'(cmdLog[i]), int'(expCmd(chs[k-1], rng)));
      for (int i = 0; i < k + 2; i++)
        check(bitLog[i] == 16, "R4", "bits per frame", bitLog[i], 16);
      for (int i = 0; i < k; i++) begin
        expBuf[chs[i]] = RES_BITS'(sampleVal(chs[i], sd));
        if (chs[i] == bad) expErr = 1;
      end
      check(tagErr === expErr, "R7", "tag error flag", int'(tagErr), int'(expErr));
      @(negedge clk);
      check(done === 1'b0, "R8", "done width", int'(done), 0);
    end
    chMask = '0;
    for (int c = 0; c < NUM_CH; c++)
      check(sampleBuf[c*RES_BITS +: RES_BITS] == expBuf[c], "R6 R12", $sformatf("slot %0d", c),
            int'(sampleBuf[c*RES_BITS +: RES_BITS]), int'(expBuf[c]));
    repeat (5) @(negedge clk);
  endtask

  bit finished = 0;
  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NUM_CH; c++) expBuf[c] = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(csN === 1'b1, "R11", "csN", int'(csN), 1);
    check(sclk === 1'b0, "R11", "sclk", int'(sclk), 0);
    check(done === 1'b0, "R11", "done", int'(done), 0);
    check(tagErr === 1'b0, "R11", "tagErr", int'(tagErr), 0);
    check(overrunCnt === '0, "R11", "overrunCnt", int'(overrunCnt), 0);
    check(sampleBuf === '0, "R11", "buffer", 0, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < 5; v++)
      run_scan(VECS[v].mask, VECS[v].rng, int'(VECS[v].seed), int'(VECS[v].bad), 0);

    // R10 empty mask
    run_scan(16'h0000, 1'b0, 1, 31, 0);

    // R9 triggers while busy are ignored and counted
    run_scan(16'h0003, 1'b0, 21, 31, 1);
    check(overrunCnt == 8'd2, "R9", "overrun count", int'(overrunCnt), 2);
    run_scan(16'h0003, 1'b1, 22, 31, 2);
    check(overrunCnt == 8'hFF, "R9", "overrun saturation", int'(overrunCnt), 255);

    check(idleViol == 0, "R4", "sclk high with csN high", idleViol, 0);
    check(gapViol == 0, "R5", "short csN high time", gapViol, 0);
    check(csN === 1'b1, "R5", "csN after scan", int'(csN), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule